// File: doc/BRIEF.md
# Exponent Range Fault Responder

This unit sits behind an extended-precision arithmetic core. It takes the result the core was about to commit, as sign, a wide signed biased exponent and a 64-bit significand, together with an event code and the exception mask bits from the control word. It returns the corrected result, a tag for the register file, the exception flags to raise, the C1 condition bit and a fault indication. One cycle separates an input from its response.

The unit handles four events: exponent overflow, exponent underflow, divide-by-zero and a denormal operand. For each event, the mask bit selects between two responses. A masked exception gets a default result: infinity, zero, or a denormalized value. An unmasked exception wraps the exponent back into range by a fixed bias of 24576 (3·2^13), so that a trap handler can rebuild the true value, or it leaves the operand unchanged.

The flag outputs last one cycle and are meant to be ORed into the status word. Overflow always produces infinity, whatever the rounding mode.

Top module: `exc_resp_unit`

## Requirements
- R1: For event code 1 (overflow) with mask bit 2 set, the result is infinity: the sign is kept, the exponent is 32767, the significand is 0x8000000000000000 and the tag is 2 (special).
- R2: A masked overflow raises flag bit 2 (overflow) and flag bit 4 (precision), and sets c1_o to 1.
- R3: For overflow with mask bit 2 clear, the exponent minus 24576 is returned, the significand is kept, the tag is 0 (valid), only flag bit 2 is raised, and c1_o is 0.
- R4: For event code 2 (underflow) with mask bit 3 set and an exponent of -63 or lower, the result is +/-zero: exponent 0, significand 0, tag 1 (zero) and c1_o equal to 0.
- R5: For a masked underflow with an exponent between -62 and 0, the significand is shifted right by (1 - exponent), the exponent becomes 0, and the tag is 0.
- R6: Both masked underflow cases raise flag bit 3 (underflow) and flag bit 4 (precision).
- R7: For underflow with mask bit 3 clear, the exponent plus 24576 is returned, the significand is kept, and only flag bit 3 is raised.
- R8: For event code 3 (divide-by-zero), flag bit 1 is raised. When mask bit 1 is set, the result is infinity with the supplied sign and tag 2. When mask bit 1 is clear, the operand passes through unchanged with tag 0.
- R9: For event code 4 (denormal operand), flag bit 0 is raised, the operand passes through unchanged, and the tag is 2.
- R10: Event code 0, and codes 5 to 7, pass the operand through unchanged with tag 0, raise no flag and set c1_o to 0.
- R11: fault_o is 1 exactly when a raised flag has its mask bit (the same bit position) clear.
- R12: The outputs register one cycle after valid_i. When valid_o is 0, flags_o, c1_o and fault_o are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| kind_i | input | 3 | Event code |
| masks_i | input | 5 | Exception masks (1 = masked), same bit order as flags_o |
| sign_i | input | 1 | Result sign |
| exp_i | input | 18 | Signed biased exponent |
| sig_i | input | 64 | Significand |
| valid_o | output | 1 | Response strobe |
| sign_o | output | 1 | Corrected sign |
| exp_o | output | 18 | Corrected exponent |
| sig_o | output | 64 | Corrected significand |
| tag_o | output | 2 | 0 valid, 1 zero, 2 special |
| flags_o | output | 5 | Raised flags: 0 denormal, 1 zero-divide, 2 overflow, 3 underflow, 4 precision |
| c1_o | output | 1 | C1 condition bit |
| fault_o | output | 1 | An unmasked exception was raised |

## Verification
A masked overflow raises both the overflow flag and the precision flag in the same cycle. The two flags have separate masks, so whether a fault occurs depends on the pair. The bench applies an overflow with overflow masked and precision unmasked. It expects infinity with C1 set and a fault caused by the precision flag alone. It compares this against the same overflow with both flags masked, which produces no fault. The same overlap arises for masked underflow: the bench checks the flush and denormalize results on either side of the -63 limit, each carrying both flags.

// File: rtl/exc_resp_pkg.sv
package exc_resp_pkg;
  localparam int FL_DEN  = 0;
  localparam int FL_ZDIV = 1;
  localparam int FL_OVF  = 2;
  localparam int FL_UNF  = 3;
  localparam int FL_PREC = 4;
  localparam int FL_W    = 5;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_OVF  = 3'd1,
    EV_UNF  = 3'd2,
    EV_ZDIV = 3'd3,
    EV_DEN  = 3'd4
  } ev_e;

  typedef enum logic [1:0] {
    TAG_NORM = 2'd0,
    TAG_ZERO = 2'd1,
    TAG_SPEC = 2'd2
  } tag_e;

  typedef enum logic [2:0] {
    ACT_PASS,
    ACT_INF,
    ACT_REB_DN,
    ACT_REB_UP,
    ACT_FLUSH,
    ACT_DENORM
  } act_e;
endpackage

// File: rtl/exc_resp_classify.sv
module exc_resp_classify
  import exc_resp_pkg::*;
#(
  parameter int EXP_W = 18,
  parameter int SIG_W = 64
) (
  input  logic [2:0]             kind_i,
  input  logic [FL_W-1:0]        masks_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output act_e                   act_o,
  output logic [FL_W-1:0]        flags_o,
  output logic                   c1_o,
  output tag_e                   tag_o
);
  // at or below this, a right shift would discard every significand bit
  localparam int ZERO_LIM = -(SIG_W - 1);

  always_comb begin
    act_o   = ACT_PASS;
    flags_o = '0;
    c1_o    = 1'b0;
    tag_o   = TAG_NORM;
    case (kind_i)
      EV_OVF: begin
        flags_o[FL_OVF] = 1'b1;
        if (masks_i[FL_OVF]) begin
          act_o            = ACT_INF;
          flags_o[FL_PREC] = 1'b1;
          c1_o             = 1'b1;
          tag_o            = TAG_SPEC;
        end else begin
          act_o = ACT_REB_DN;
        end
      end
      EV_UNF: begin
        flags_o[FL_UNF] = 1'b1;
        if (masks_i[FL_UNF]) begin
          flags_o[FL_PREC] = 1'b1;
          if (int'(exp_i) <= ZERO_LIM) begin
            act_o = ACT_FLUSH;
            tag_o = TAG_ZERO;
          end else begin
            act_o = ACT_DENORM;
          end
        end else begin
          act_o = ACT_REB_UP;
        end
      end
      EV_ZDIV: begin
        flags_o[FL_ZDIV] = 1'b1;
        if (masks_i[FL_ZDIV]) begin
          act_o = ACT_INF;
          tag_o = TAG_SPEC;
        end
      end
      EV_DEN: begin
        flags_o[FL_DEN] = 1'b1;
        tag_o           = TAG_SPEC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_resp_datapath.sv
module exc_resp_datapath
  import exc_resp_pkg::*;
#(
  parameter int EXP_W     = 18,
  parameter int FMT_EXP_W = 15,
  parameter int SIG_W     = 64
) (
  input  act_e             act_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int SHW = $clog2(SIG_W);
  localparam logic [EXP_W-1:0] EXP_INF = EXP_W'((1 << FMT_EXP_W) - 1);
  localparam logic [EXP_W-1:0] REBIAS  = EXP_W'(3 << (FMT_EXP_W - 2));
  localparam logic [SIG_W-1:0] SIG_INF = {1'b1, {(SIG_W-1){1'b0}}};

  logic [EXP_W-1:0] deficit;
  logic [SHW-1:0]   shamt;

  // denormals carry an effective exponent of 1
  assign deficit = EXP_W'(1) - exp_i;
  assign shamt   = deficit[SHW-1:0];

  always_comb begin
    exp_o = exp_i;
    sig_o = sig_i;
    case (act_i)
      ACT_INF:    begin exp_o = EXP_INF;          sig_o = SIG_INF;        end
      ACT_REB_DN: begin exp_o = exp_i - REBIAS;                           end
      ACT_REB_UP: begin exp_o = exp_i + REBIAS;                           end
      ACT_FLUSH:  begin exp_o = '0;               sig_o = '0;             end
      ACT_DENORM: begin exp_o = '0;               sig_o = sig_i >> shamt; end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_resp_unit.sv
module exc_resp_unit
  import exc_resp_pkg::*;
#(
  parameter int EXP_W     = 18,
  parameter int FMT_EXP_W = 15,
  parameter int SIG_W     = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       kind_i,
  input  logic [4:0]       masks_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [1:0]       tag_o,
  output logic [4:0]       flags_o,
  output logic             c1_o,
  output logic             fault_o
);
  localparam logic [EXP_W-1:0] EXP_INF = EXP_W'((1 << FMT_EXP_W) - 1);

  act_e             act;
  logic [FL_W-1:0]  flags;
  logic             c1;
  tag_e             tag;
  logic [EXP_W-1:0] exp_d;
  logic [SIG_W-1:0] sig_d;

  exc_resp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_classify (
    .kind_i (kind_i),
    .masks_i(masks_i),
    .exp_i  ($signed(exp_i)),
    .act_o  (act),
    .flags_o(flags),
    .c1_o   (c1),
    .tag_o  (tag)
  );

  exc_resp_datapath #(.EXP_W(EXP_W), .FMT_EXP_W(FMT_EXP_W), .SIG_W(SIG_W)) i_datapath (
    .act_i(act),
    .exp_i(exp_i),
    .sig_i(sig_i),
    .exp_o(exp_d),
    .sig_o(sig_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      sig_o   <= '0;
      tag_o   <= TAG_NORM;
      flags_o <= '0;
      c1_o    <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      flags_o <= valid_i ? flags : '0;
      c1_o    <= valid_i & c1;
      fault_o <= valid_i & |(flags & ~masks_i);
      if (valid_i) begin
        sign_o <= sign_i;
        exp_o  <= exp_d;
        sig_o  <= sig_d;
        tag_o  <= tag;
      end
    end
  end

  a_r12_flags_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (flags_o == '0) && !c1_o && !fault_o);

  a_r1_masked_ovf_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[FL_OVF] && flags_o[FL_PREC] |-> exp_o == EXP_INF && tag_o == TAG_SPEC);

  a_r2_ovf_round_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[FL_OVF] && tag_o == TAG_SPEC |-> c1_o && flags_o[FL_PREC]);

  a_r3_unmasked_ovf_sig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[FL_OVF] && !flags_o[FL_PREC] |-> sig_o == $past(sig_i));

  a_r4_flush_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && tag_o == TAG_ZERO |-> sig_o == '0 && exp_o == '0 && !c1_o);

  a_r10_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o == '0 |-> sig_o == $past(sig_i) && exp_o == $past(exp_i));

  a_r11_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> fault_o == |(flags_o & ~$past(masks_i)));
endmodule

// File: tb/test_exc_resp_unit.sv
`timescale 1ns/1ps
module test_exc_resp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [4:0]  masks_i = '0;
  logic        sign_i = 1'b0;
  logic [17:0] exp_i = '0;
  logic [63:0] sig_i = '0;
  logic        valid_o, sign_o, c1_o, fault_o;
  logic [17:0] exp_o;
  logic [63:0] sig_o;
  logic [1:0]  tag_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  exc_resp_unit i_exc_resp_unit (.*);

  typedef struct packed {
    logic [2:0]  kind;
    logic [4:0]  masks;
    logic        sign;
    logic [17:0] exp;
    logic [63:0] sig;
    logic        e_sign;
    logic [17:0] e_exp;
    logic [63:0] e_sig;
    logic [1:0]  e_tag;
    logic [4:0]  e_fl;
    logic        e_c1;
    logic        e_fault;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] INF_SIG = 64'h8000_0000_0000_0000;
  localparam logic [63:0] S1 = 64'hC123_4567_89AB_CDEF;

  localparam vec_t VECS [15] = '{
    // R1 R2 masked overflow
    '{3'd1, 5'h1f, 1'b1, 18'd33000, S1, 1'b1, 18'd32767, INF_SIG, 2'd2, 5'h14, 1'b1, 1'b0, 8'd1},
    // R3 unmasked overflow
    '{3'd1, 5'h1b, 1'b0, 18'd33000, S1, 1'b0, 18'd8424, S1, 2'd0, 5'h04, 1'b0, 1'b1, 8'd3},
    // R4 R6 flush well below limit
    '{3'd2, 5'h1f, 1'b1, -18'sd70, S1, 1'b1, 18'd0, 64'd0, 2'd1, 5'h18, 1'b0, 1'b0, 8'd4},
    // R4 flush at the -63 limit
    '{3'd2, 5'h1f, 1'b0, -18'sd63, S1, 1'b0, 18'd0, 64'd0, 2'd1, 5'h18, 1'b0, 1'b0, 8'd4},
    // R5 R6 denormalize at -62: shift 63
    '{3'd2, 5'h1f, 1'b0, -18'sd62, INF_SIG, 1'b0, 18'd0, 64'd1, 2'd0, 5'h18, 1'b0, 1'b0, 8'd5},
    // R5 exponent 0: shift 1
    '{3'd2, 5'h1f, 1'b1, 18'd0, INF_SIG, 1'b1, 18'd0, 64'h4000_0000_0000_0000, 2'd0, 5'h18, 1'b0, 1'b0, 8'd5},
    // R5 exponent -1: shift 2
    '{3'd2, 5'h1f, 1'b0, -18'sd1, 64'hA000_0000_0000_0002, 1'b0, 18'd0, 64'h2800_0000_0000_0000, 2'd0, 5'h18, 1'b0, 1'b0, 8'd5},
    // R7 unmasked underflow
    '{3'd2, 5'h17, 1'b1, -18'sd100, S1, 1'b1, 18'd24476, S1, 2'd0, 5'h08, 1'b0, 1'b1, 8'd7},
    // R8 masked zero divide
    '{3'd3, 5'h1f, 1'b1, 18'd123, S1, 1'b1, 18'd32767, INF_SIG, 2'd2, 5'h02, 1'b0, 1'b0, 8'd8},
    // R8 unmasked zero divide
    '{3'd3, 5'h1d, 1'b0, 18'd123, S1, 1'b0, 18'd123, S1, 2'd0, 5'h02, 1'b0, 1'b1, 8'd8},
    // R9 masked denormal operand
    '{3'd4, 5'h1f, 1'b0, 18'd5, S1, 1'b0, 18'd5, S1, 2'd2, 5'h01, 1'b0, 1'b0, 8'd9},
    // R9 R11 unmasked denormal operand
    '{3'd4, 5'h1e, 1'b1, 18'd5, S1, 1'b1, 18'd5, S1, 2'd2, 5'h01, 1'b0, 1'b1, 8'd9},
    // R10 unknown code
    '{3'd7, 5'h00, 1'b1, 18'd40000, S1, 1'b1, 18'd40000, S1, 2'd0, 5'h00, 1'b0, 1'b0, 8'd10},
    // R10 no event
    '{3'd0, 5'h00, 1'b0, -18'sd9, S1, 1'b0, -18'sd9, S1, 2'd0, 5'h00, 1'b0, 1'b0, 8'd10},
    // R11 overflow masked, precision unmasked
    '{3'd1, 5'h0f, 1'b0, 18'd40000, S1, 1'b0, 18'd32767, INF_SIG, 2'd2, 5'h14, 1'b1, 1'b1, 8'd11}
  };

  task automatic chk(input string what, input int req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t v);
    chk("valid", v.req, 128'(valid_o), 128'(1'b1));
    chk("sign", v.req, 128'(sign_o), 128'(v.e_sign));
    chk("exp", v.req, 128'(exp_o), 128'(v.e_exp));
    chk("sig", v.req, 128'(sig_o), 128'(v.e_sig));
    chk("tag", v.req, 128'(tag_o), 128'(v.e_tag));
    chk("flags", v.req, 128'(flags_o), 128'(v.e_fl));
    chk("c1", v.req, 128'(c1_o), 128'(v.e_c1));
    chk("fault", v.req, 128'(fault_o), 128'(v.e_fault));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("reset valid", 12, 128'(valid_o), 128'(1'b0));
    chk("reset flags", 12, 128'({flags_o, c1_o, fault_o}), 128'(0));
    chk("reset data", 12, 128'({exp_o, tag_o}), 128'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // back-to-back walk of the table: one cycle latency
    for (int i = 0; i < 15; i++) begin
      valid_i = 1'b1;
      kind_i  = VECS[i].kind;
      masks_i = VECS[i].masks;
      sign_i  = VECS[i].sign;
      exp_i   = VECS[i].exp;
      sig_i   = VECS[i].sig;
      @(negedge clk_i);
      check_vec(VECS[i]);
    end

    // R12 flags are a pulse: drop valid with an overflow still on the inputs
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("idle valid", 12, 128'(valid_o), 128'(1'b0));
    chk("idle flags", 12, 128'({flags_o, c1_o, fault_o}), 128'(0));
    // R12 data held while idle
    chk("idle hold exp", 12, 128'(exp_o), 128'(18'd32767));

    // R2 masked overflow then R4 flush: c1 must go from set to clear
    valid_i = 1'b1; kind_i = 3'd1; masks_i = 5'h1f; exp_i = 18'd32767; sig_i = S1;
    @(negedge clk_i);
    chk("ovf at boundary c1", 2, 128'(c1_o), 128'(1'b1));
    kind_i = 3'd2; exp_i = -18'sd64;
    @(negedge clk_i);
    chk("flush c1 clear", 4, 128'({c1_o, tag_o}), 128'({1'b0, 2'd1}));
    valid_i = 1'b0;
    @(negedge clk_i);

    // R12 asynchronous reset mid-stream
    valid_i = 1'b1; kind_i = 3'd3; masks_i = 5'h00;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("async reset", 12, 128'({valid_o, flags_o, fault_o}), 128'(0));
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule